// File: doc/BRIEF.md
# Two-Stage Baud-Rate Generator

This block derives the timing strobes for a serial transmitter and receiver from one reference clock. A mode bit either passes every reference clock edge through or keeps only one edge in eight, using a free-running prescaler. A programmable clock divisor counts the selected edges and raises a one-cycle sample enable at the end of each group. A second programmable counter, the bit divisor, counts those sample enables and raises a baud tick on the last one of each group. The resulting bit rate is the selected clock rate divided by (clock divisor × (bit divisor + 1)).

Software programs the block through a narrow write port with three word addresses: 0 holds the prescaler select in bit 0, 1 holds the clock divisor and 2 holds the bit divisor. Illegal divisor values are refused in hardware, so the live settings are always usable. A new divisor does not cut short the period that is already running. Each counter picks up its new limit only when it reaches its current terminal count.

Top module: `ubg_top`

## Requirements
- R1: With mode bit 0 clear, `sample_en` is high in exactly one cycle out of every D cycles, where D is the clock divisor.
- R2: With mode bit 0 set, `sample_en` is high in exactly one cycle out of every 8·D cycles.
- R3: `baud_tick` is high only in a cycle where `sample_en` is high, and it is high on exactly every (B+1)-th sample enable, where B is the bit divisor. It is never high in two consecutive cycles.
- R4: A write to address 1 keeps only `wr_data[15:0]`. If those 16 bits are zero, the write is ignored and the previous clock divisor stays in force.
- R5: A write to address 2 keeps only `wr_data[7:0]`. If that byte is below 4, the write is ignored and the previous bit divisor stays in force.
- R6: After reset the clock divisor is 651, the bit divisor is 15 and mode bit 0 is clear. The prescaler and both counters start from zero, so the first `sample_en` comes 650 cycles after reset release and the first `baud_tick` comes 10415 cycles after it.
- R7: A divisor write that lands mid-period takes effect only after that counter's next terminal count. The period in progress keeps its old length, and the following period uses the new one.
- R8: A write to address 3, or any bit of address 0 other than bit 0, leaves both strobe rates unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 mode, 1 clock divisor, 2 bit divisor, 3 unused |
| wr_data | input | 32 | Write data word |
| sample_en | output | 1 | One-cycle sample-rate enable |
| baud_tick | output | 1 | One-cycle bit-rate tick |

## Verification
A counter that holds a wrong count or a wrong limit shows up at once as a `sample_en` or `baud_tick` spacing that differs from the divisor arithmetic. A stage-one error appears within one sample period, and a stage-two error within one bit period. A wrongly accepted divisor write changes the very next period after the old one completes. A reload taken at the wrong moment gives a runt or stretched interval right where the write landed. The bench therefore measures every interval between strobes against the product of the programmed values, across a sweep of both prescaler settings and several divisor pairs.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
   // Register word addresses on the write port
   typedef enum logic [1:0] {
      UBG_A_MODE = 2'd0,
      UBG_A_CDIV = 2'd1,
      UBG_A_BDIV = 2'd2,
      UBG_A_NONE = 2'd3
   } ubg_addr_e;

   localparam int unsigned UBG_DATA_W = 32;
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
   import ubg_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned CW     = 16,
   parameter int unsigned BW     = 8,
   parameter int unsigned C_RST  = 651,
   parameter int unsigned B_RST  = 15,
   parameter int unsigned B_MIN  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          sel_div8,
   output logic [CW-1:0] cdiv,
   output logic [BW-1:0] bdiv
);
   localparam logic [BW-1:0] BMIN_V = BW'(B_MIN);

   logic [CW-1:0] cdiv_cand;
   logic [BW-1:0] bdiv_cand;
   logic          cdiv_ok;
   logic          bdiv_ok;
   logic [DW-1:0] unused_wdata;

   assign cdiv_cand    = wr_data[CW-1:0];
   assign bdiv_cand    = wr_data[BW-1:0];
   assign cdiv_ok      = (cdiv_cand != '0);
   assign bdiv_ok      = (bdiv_cand >= BMIN_V);
   assign unused_wdata = wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_div8 <= 1'b0;
         cdiv     <= CW'(C_RST);
         bdiv     <= BW'(B_RST);
      end else if (wr_en) begin
         unique case (ubg_addr_e'(wr_addr))
            UBG_A_MODE: sel_div8 <= wr_data[0];
            UBG_A_CDIV: if (cdiv_ok) cdiv <= cdiv_cand;
            UBG_A_BDIV: if (bdiv_ok) bdiv <= bdiv_cand;
            default: ;
         endcase
      end
   end

   // R4
   cdiv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cdiv != '0);

   // R5
   bdiv_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bdiv >= BMIN_V);

   // R8
   none_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> ($stable(cdiv) && $stable(bdiv) && $stable(sel_div8)));
endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
   parameter int unsigned PRE_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   output logic ce
);
   logic [PRE_LOG2-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt <= '0;
      else        pcnt <= pcnt + PRE_LOG2'(1);
   end

   assign ce = sel ? (pcnt == '1) : 1'b1;

   // R2
   pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && ce) |=> !(sel && ce));
endmodule

// File: rtl/ubg_stage.sv
module ubg_stage #(
   parameter int unsigned W        = 16,
   parameter int unsigned RST_LAST = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] last_in,
   output logic         tick
);
   logic [W-1:0] cnt;
   logic [W-1:0] last_q;

   assign tick = en && (cnt == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         last_q <= W'(RST_LAST);
      end else if (en) begin
         if (cnt == last_q) begin
            cnt    <= '0;
            last_q <= last_in;
         end else begin
            cnt    <= cnt + W'(1);
         end
      end
   end

   // R1
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_q);

   // R7
   last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(last_q));
endmodule

// File: rtl/ubg_top.sv
module ubg_top
   import ubg_pkg::*;
#(
   parameter int unsigned DW       = UBG_DATA_W,
   parameter int unsigned CW       = 16,
   parameter int unsigned BW       = 8,
   parameter int unsigned PRE_LOG2 = 3,
   parameter int unsigned C_RST    = 651,
   parameter int unsigned B_RST    = 15,
   parameter int unsigned B_MIN    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          sample_en,
   output logic          baud_tick
);
   generate
      if (PRE_LOG2 < 1) begin : g_bad_pre
         $error("ubg_top: PRE_LOG2 must be at least 1");
      end
      if (DW < CW || DW < BW) begin : g_bad_dw
         $error("ubg_top: write data narrower than a divisor field");
      end
      if (C_RST == 0 || C_RST >= (2 ** CW)) begin : g_bad_crst
         $error("ubg_top: clock divisor reset value out of range");
      end
      if (B_MIN < 1 || B_RST < B_MIN || B_RST >= (2 ** BW)) begin : g_bad_brst
         $error("ubg_top: bit divisor reset value or floor out of range");
      end
   endgenerate

   logic          sel_div8;
   logic [CW-1:0] cdiv;
   logic [BW-1:0] bdiv;
   logic          ce;

   ubg_regs #(
      .DW(DW), .CW(CW), .BW(BW),
      .C_RST(C_RST), .B_RST(B_RST), .B_MIN(B_MIN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sel_div8(sel_div8), .cdiv(cdiv), .bdiv(bdiv)
   );

   ubg_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(sel_div8), .ce(ce)
   );

   ubg_stage #(.W(CW), .RST_LAST(C_RST - 1)) u_clkdiv (
      .clk(clk), .rst_n(rst_n), .en(ce),
      .last_in(cdiv - CW'(1)), .tick(sample_en)
   );

   ubg_stage #(.W(BW), .RST_LAST(B_RST)) u_bitdiv (
      .clk(clk), .rst_n(rst_n), .en(sample_en),
      .last_in(bdiv), .tick(baud_tick)
   );

   // R3
   baud_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> sample_en);

   // R3
   baud_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick);
endmodule

// File: tb/sim_ubg_top.sv
module sim_ubg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic        sample_en;
   logic        baud_tick;

   int cyc = 0;
   int checks = 0;
   int errs = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   ubg_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sample_en(sample_en), .baud_tick(baud_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic next_sample(output int t);
      do @(negedge clk); while (!sample_en);
      t = cyc;
   endtask

   task automatic next_baud(output int t);
      do @(negedge clk); while (!baud_tick);
      t = cyc;
   endtask

   task automatic resync();
      int t;
      next_baud(t);
      next_baud(t);
   endtask

   // Measure one full bit period: every sample spacing and the tick position
   task automatic measure(input int mode, input int d, input int b, input string req);
      int t0, prev, ts, p;
      p = (mode != 0) ? 8 * d : d;
      next_baud(t0);
      prev = t0;
      for (int k = 1; k <= b + 1; k++) begin
         next_sample(ts);
         chk(ts - prev == p, req, ts - prev, p);
         if (k <= b) chk(baud_tick == 1'b0, {req, " R3 early tick"}, int'(baud_tick), 0);
         prev = ts;
      end
      chk(baud_tick == 1'b1, {req, " R3 tick at sample B+1"}, int'(baud_tick), 1);
      chk(ts - t0 == p * (b + 1), {req, " R3 bit period"}, ts - t0, p * (b + 1));
   endtask

   task automatic cfg(input int mode, input int d, input int b);
      wr(2'd0, 32'(mode));
      wr(2'd1, 32'(d));
      wr(2'd2, 32'(b));
      resync();
   endtask

   initial begin
      int t, t0, t1, t2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6: strobes idle right after release, then reset divisors in force
      chk(sample_en == 1'b0, "R6 sample_en at release", int'(sample_en), 0);
      chk(baud_tick == 1'b0, "R6 baud_tick at release", int'(baud_tick), 0);
      next_sample(t);
      chk(t == 650, "R6 first sample_en", t, 650);
      next_baud(t);
      chk(t == 10415, "R6 first baud_tick", t, 10415);

      // R1, R2, R3 sweep over both prescaler settings
      for (int m = 0; m < 2; m++) begin
         for (int di = 0; di < 5; di++) begin
            for (int bi = 0; bi < 2; bi++) begin
               int dv, bv;
               dv = (di == 0) ? 1 : (di == 1) ? 2 : (di == 2) ? 3 : (di == 3) ? 5 : 7;
               bv = (bi == 0) ? 4 : 6;
               cfg(m, dv, bv);
               measure(m, dv, bv, (m == 0) ? "R1" : "R2");
            end
         end
      end

      // R4: zero low half ignored, upper bits dropped
      cfg(0, 4, 4);
      wr(2'd1, 32'h0000_0000);
      wr(2'd1, 32'h0001_0000);
      resync();
      measure(0, 4, 4, "R4 zero write ignored");
      wr(2'd1, 32'hABCD_0003);
      resync();
      measure(0, 3, 4, "R4 low 16 bits kept");

      // R5: byte below floor ignored, upper bits dropped
      wr(2'd2, 32'h0000_0003);
      wr(2'd2, 32'h0000_0203);
      resync();
      measure(0, 3, 4, "R5 small write ignored");
      wr(2'd2, 32'h0000_0106);
      resync();
      measure(0, 3, 6, "R5 low 8 bits kept");

      // R8: unused address and spare mode bits have no effect
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd0, 32'hFFFF_FFFE);
      resync();
      measure(0, 3, 6, "R8 no effect");

      // R7: clock divisor change waits for terminal count
      cfg(0, 5, 4);
      next_sample(t0);
      wr(2'd1, 32'd9);
      next_sample(t1);
      chk(t1 - t0 == 5, "R7 sample period in flight", t1 - t0, 5);
      next_sample(t2);
      chk(t2 - t1 == 9, "R7 sample period after reload", t2 - t1, 9);

      // R7: bit divisor change waits for terminal count
      resync();
      next_baud(t0);
      wr(2'd2, 32'd7);
      next_baud(t1);
      chk(t1 - t0 == 45, "R7 bit period in flight", t1 - t0, 45);
      next_baud(t2);
      chk(t2 - t1 == 72, "R7 bit period after reload", t2 - t1, 72);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog R1 R3 run did not complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end
endmodule